// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the pixel-clock-domain scan timing for a TFT panel. From a set of programmed fields it walks a horizontal pixel counter and a vertical line counter through each frame. It decodes horizontal sync, vertical sync and a data-enable window from them, and it reports the current position to the pixel path. Each line runs through four phases in a fixed order: visible pixels, front porch, sync and back porch. Each frame runs through the same four phases counted in lines.

The fields use biased encodings. The visible width is given in units of sixteen pixels, minus one. The horizontal porches and sync width are each given minus one. The vertical porches are given as plain line counts, and the vertical sync width and the line count are given minus one. Each sync output has its own polarity control. Vertical sync changes state only at the trailing edge of a horizontal sync pulse, not at its leading edge.

Fields and polarity controls are captured only while the raster is stopped. Raising the enable starts a frame. While the enable stays high, frames follow one another without a gap. When the enable drops, the frame in progress runs to its end, a frame-done pulse follows, and the block goes idle.

Top module: `raster_timing_gen`

## Requirements
- R1: A line lasts (ppl_i+1)*PIX_UNIT visible clocks, then hfp_i+1 front-porch clocks, then hsw_i+1 sync clocks, then hbp_i+1 back-porch clocks. pix_cnt_o counts 0 up to the line length minus one and then wraps to 0.
- R2: A frame has lpp_i+1 visible lines, then vfp_i front-porch lines (which may be zero), then vsw_i+1 sync lines, then vbp_i back-porch lines (which may be zero). line_cnt_o gives the line of the current pixel and advances when pix_cnt_o wraps.
- R3: de_o is 1 exactly when pix_cnt_o is below the visible width and line_cnt_o is below the visible line count.
- R4: During the horizontal sync phase hsync_o equals NOT hs_inv; at all other positions, and while idle, it equals hs_inv. So hs_inv=0 gives an active-high pulse and hs_inv=1 gives an active-low pulse.
- R5: The vertical sync state is updated only at the pixel where horizontal sync ends (the first back-porch pixel). There it becomes active when the line is in the vertical sync range. It starts each run inactive, and vsync_o equals the active state XOR vs_inv.
- R6: eof_o is a one-cycle pulse that is issued exactly when the outputs show the last pixel of the last line, once per frame.
- R7: If enable_i is low during any cycle of a frame, that frame completes. frame_done_o then pulses for the one cycle after its eof_o. From that cycle on, de_o is 0, both counters read 0 and both syncs sit at their inactive level until the next start.
- R8: While idle, a high enable_i starts a frame, and its first output cycle shows pixel 0 of line 0 with de_o high. If enable_i is still high at the end of a frame, the next frame's pixel 0 of line 0 follows in the very next cycle.
- R9: Timing fields and polarity controls are sampled only while idle. Changing them during a run has no effect on any output until the block has stopped.
- R10: After reset, hsync_o, vsync_o, de_o, eof_o, frame_done_o and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Raster run request; low stops after the current frame |
| ppl_i | input | PPL_W (7) | Visible width in PIX_UNIT pixels, minus one |
| hfp_i | input | HF_W (10) | Horizontal front porch clocks minus one |
| hsw_i | input | HF_W (10) | Horizontal sync clocks minus one |
| hbp_i | input | HF_W (10) | Horizontal back porch clocks minus one |
| lpp_i | input | LPP_W (11) | Visible lines minus one |
| vfp_i | input | VP_W (8) | Vertical front porch lines |
| vsw_i | input | VSW_W (6) | Vertical sync lines minus one |
| vbp_i | input | VP_W (8) | Vertical back porch lines |
| hs_inv_i | input | 1 | Horizontal sync polarity invert |
| vs_inv_i | input | 1 | Vertical sync polarity invert |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable, visible pixel window |
| pix_cnt_o | output | HCW (13) | Pixel position within the line |
| line_cnt_o | output | VCW (12) | Line position within the frame |
| eof_o | output | 1 | End-of-frame pulse |
| frame_done_o | output | 1 | Pulse after the last frame once stopped |

## Verification
The bench builds the block with the field widths cut down to PPL_W=2, HF_W=2, LPP_W=2, VP_W=2 and VSW_W=1, while PIX_UNIT stays at 16. With these widths the bench can sweep each field up to its largest value and also cover zero-line vertical porches, both sync polarities, back-to-back frames and mid-run field changes. Every configuration runs to completion, and each output is compared in every cycle with a position model that the bench builds from the field arithmetic.

// File: rtl/raster_timing_pkg.sv
package raster_timing_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rtg_state_e;

endpackage

// File: rtl/rtg_cfg.sv
// Shadow register for the timing fields: converts biased fields into absolute
// phase boundaries, loaded only while the raster is idle.
module rtg_cfg #(
  parameter int PIX_UNIT = 16,
  parameter int PPL_W    = 7,
  parameter int HF_W     = 10,
  parameter int LPP_W    = 11,
  parameter int VP_W     = 8,
  parameter int VSW_W    = 6,
  parameter int HCW      = 13,
  parameter int VCW      = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PPL_W-1:0] ppl_i,
  input  logic [HF_W-1:0]  hfp_i,
  input  logic [HF_W-1:0]  hsw_i,
  input  logic [HF_W-1:0]  hbp_i,
  input  logic [LPP_W-1:0] lpp_i,
  input  logic [VP_W-1:0]  vfp_i,
  input  logic [VSW_W-1:0] vsw_i,
  input  logic [VP_W-1:0]  vbp_i,
  input  logic             hs_inv_i,
  input  logic             vs_inv_i,
  output logic [HCW-1:0]   h_act_end_o,
  output logic [HCW-1:0]   h_sync_beg_o,
  output logic [HCW-1:0]   h_sync_end_o,
  output logic [HCW-1:0]   h_last_o,
  output logic [VCW-1:0]   v_act_end_o,
  output logic [VCW-1:0]   v_sync_beg_o,
  output logic [VCW-1:0]   v_sync_end_o,
  output logic [VCW-1:0]   v_last_o,
  output logic             hs_inv_o,
  output logic             vs_inv_o
);

  localparam logic [HCW-1:0] UNIT  = HCW'(PIX_UNIT);
  localparam logic [HCW-1:0] H_ONE = HCW'(1);
  localparam logic [VCW-1:0] V_ONE = VCW'(1);

  logic [HCW-1:0] h_ae, h_ss, h_se, h_ls;
  logic [VCW-1:0] v_ae, v_ss, v_se, v_ls;

  always_comb begin
    h_ae = (HCW'(ppl_i) + H_ONE) * UNIT;
    h_ss = h_ae + HCW'(hfp_i) + H_ONE;
    h_se = h_ss + HCW'(hsw_i) + H_ONE;
    h_ls = h_se + HCW'(hbp_i);
    v_ae = VCW'(lpp_i) + V_ONE;
    v_ss = v_ae + VCW'(vfp_i);
    v_se = v_ss + VCW'(vsw_i) + V_ONE;
    v_ls = v_se + VCW'(vbp_i) - V_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_act_end_o  <= '0;
      h_sync_beg_o <= '0;
      h_sync_end_o <= '0;
      h_last_o     <= '0;
      v_act_end_o  <= '0;
      v_sync_beg_o <= '0;
      v_sync_end_o <= '0;
      v_last_o     <= '0;
      hs_inv_o     <= 1'b0;
      vs_inv_o     <= 1'b0;
    end else if (load_i) begin
      h_act_end_o  <= h_ae;
      h_sync_beg_o <= h_ss;
      h_sync_end_o <= h_se;
      h_last_o     <= h_ls;
      v_act_end_o  <= v_ae;
      v_sync_beg_o <= v_ss;
      v_sync_end_o <= v_se;
      v_last_o     <= v_ls;
      hs_inv_o     <= hs_inv_i;
      vs_inv_o     <= vs_inv_i;
    end
  end

  // R9
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(h_last_o) && $stable(v_last_o) && $stable(hs_inv_o) && $stable(vs_inv_o)));

endmodule

// File: rtl/rtg_axis.sv
// Wrapping position counter, shared by the pixel and line axes.
module rtg_axis #(
  parameter int CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [CW-1:0] last_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);

  assign wrap_o = adv_i && (cnt_o == last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (wrap_o)  cnt_o <= '0;
    else if (adv_i)   cnt_o <= cnt_o + 1'b1;
  end

  // R1
  axis_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_o && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));

  // R2
  axis_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (cnt_o <= last_i));

endmodule

// File: rtl/rtg_out.sv
// Output register stage: all panel-facing signals leave from flops, aligned.
module rtg_out #(
  parameter int HCW = 13,
  parameter int VCW = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [HCW-1:0] h_cnt_i,
  input  logic [VCW-1:0] v_cnt_i,
  input  logic           de_i,
  input  logic           hs_i,
  input  logic           vs_i,
  input  logic           eof_i,
  input  logic           done_i,
  input  logic           hs_inv_i,
  input  logic           vs_inv_i,
  output logic           run_o,
  output logic           hsync_o,
  output logic           vsync_o,
  output logic           de_o,
  output logic [HCW-1:0] pix_cnt_o,
  output logic [VCW-1:0] line_cnt_o,
  output logic           eof_o,
  output logic           frame_done_o
);

  logic done_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o        <= 1'b0;
      hsync_o      <= 1'b0;
      vsync_o      <= 1'b0;
      de_o         <= 1'b0;
      pix_cnt_o    <= '0;
      line_cnt_o   <= '0;
      eof_o        <= 1'b0;
      done_d       <= 1'b0;
      frame_done_o <= 1'b0;
    end else begin
      run_o        <= run_i;
      hsync_o      <= hs_inv_i ^ (run_i & hs_i);
      vsync_o      <= vs_inv_i ^ (run_i & vs_i);
      de_o         <= run_i & de_i;
      pix_cnt_o    <= run_i ? h_cnt_i : '0;
      line_cnt_o   <= run_i ? v_cnt_i : '0;
      eof_o        <= eof_i;
      done_d       <= done_i;
      frame_done_o <= done_d;
    end
  end

  // R7
  done_after_eof_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> $past(eof_o));

  // R6
  eof_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import raster_timing_pkg::*; #(
  parameter int PIX_UNIT = 16,
  parameter int PPL_W    = 7,
  parameter int HF_W     = 10,
  parameter int LPP_W    = 11,
  parameter int VP_W     = 8,
  parameter int VSW_W    = 6,
  localparam int H_MAX   = PIX_UNIT * (2 ** PPL_W) + 3 * (2 ** HF_W),
  localparam int V_MAX   = (2 ** LPP_W) + 2 * (2 ** VP_W) + (2 ** VSW_W),
  localparam int HCW     = $clog2(H_MAX + 1),
  localparam int VCW     = $clog2(V_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [PPL_W-1:0] ppl_i,
  input  logic [HF_W-1:0]  hfp_i,
  input  logic [HF_W-1:0]  hsw_i,
  input  logic [HF_W-1:0]  hbp_i,
  input  logic [LPP_W-1:0] lpp_i,
  input  logic [VP_W-1:0]  vfp_i,
  input  logic [VSW_W-1:0] vsw_i,
  input  logic [VP_W-1:0]  vbp_i,
  input  logic             hs_inv_i,
  input  logic             vs_inv_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic [HCW-1:0]   pix_cnt_o,
  output logic [VCW-1:0]   line_cnt_o,
  output logic             eof_o,
  output logic             frame_done_o
);

  rtg_state_e state_q, state_d;
  logic run, stop_q, done_raw, eof_raw;

  logic [HCW-1:0] h_ae, h_ss, h_se, h_ls, h_cnt;
  logic [VCW-1:0] v_ae, v_ss, v_se, v_ls, v_cnt;
  logic hs_inv_q, vs_inv_q, h_wrap, v_wrap;
  logic de_raw, hs_raw, v_in_sync, vs_now, vs_flag_q, out_run;

  assign run = (state_q == ST_RUN);

  rtg_cfg #(
    .PIX_UNIT(PIX_UNIT), .PPL_W(PPL_W), .HF_W(HF_W), .LPP_W(LPP_W),
    .VP_W(VP_W), .VSW_W(VSW_W), .HCW(HCW), .VCW(VCW)
  ) u_cfg (
    .clk_i, .rst_ni,
    .load_i      (!run),
    .ppl_i, .hfp_i, .hsw_i, .hbp_i, .lpp_i, .vfp_i, .vsw_i, .vbp_i,
    .hs_inv_i, .vs_inv_i,
    .h_act_end_o (h_ae),
    .h_sync_beg_o(h_ss),
    .h_sync_end_o(h_se),
    .h_last_o    (h_ls),
    .v_act_end_o (v_ae),
    .v_sync_beg_o(v_ss),
    .v_sync_end_o(v_se),
    .v_last_o    (v_ls),
    .hs_inv_o    (hs_inv_q),
    .vs_inv_o    (vs_inv_q)
  );

  rtg_axis #(.CW(HCW)) u_h_axis (
    .clk_i, .rst_ni,
    .clr_i (!run),
    .adv_i (run),
    .last_i(h_ls),
    .cnt_o (h_cnt),
    .wrap_o(h_wrap)
  );

  rtg_axis #(.CW(VCW)) u_v_axis (
    .clk_i, .rst_ni,
    .clr_i (!run),
    .adv_i (h_wrap),
    .last_i(v_ls),
    .cnt_o (v_cnt),
    .wrap_o(v_wrap)
  );

  // Phase decode at the counter stage
  always_comb begin
    de_raw    = (h_cnt < h_ae) && (v_cnt < v_ae);
    hs_raw    = (h_cnt >= h_ss) && (h_cnt < h_se);
    v_in_sync = (v_cnt >= v_ss) && (v_cnt < v_se);
    // vertical sync only moves at the trailing edge of horizontal sync
    vs_now    = (h_cnt == h_se) ? v_in_sync : vs_flag_q;
    eof_raw   = h_wrap && v_wrap;
    done_raw  = eof_raw && (stop_q || !enable_i);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (enable_i) state_d = ST_RUN;
      ST_RUN:  if (done_raw) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      stop_q    <= 1'b0;
      vs_flag_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      vs_flag_q <= run & vs_now;
      if (!run)           stop_q <= 1'b0;
      else if (!enable_i) stop_q <= 1'b1;
    end
  end

  rtg_out #(.HCW(HCW), .VCW(VCW)) u_out (
    .clk_i, .rst_ni,
    .run_i       (run),
    .h_cnt_i     (h_cnt),
    .v_cnt_i     (v_cnt),
    .de_i        (de_raw),
    .hs_i        (hs_raw),
    .vs_i        (vs_now),
    .eof_i       (eof_raw),
    .done_i      (done_raw),
    .hs_inv_i    (hs_inv_q),
    .vs_inv_i    (vs_inv_q),
    .run_o       (out_run),
    .hsync_o, .vsync_o, .de_o, .pix_cnt_o, .line_cnt_o, .eof_o, .frame_done_o
  );

  // R5
  vs_on_hs_trail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_run && $past(out_run) && (vsync_o != $past(vsync_o)))
      |-> (($past(hsync_o) != hs_inv_q) && (hsync_o == hs_inv_q)));

  // R3
  de_no_hs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_o == hs_inv_q));

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_run |-> (!de_o && !eof_o && (pix_cnt_o == '0) && (line_cnt_o == '0)));

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PU    = 16;
  localparam int PPL_W = 2;
  localparam int HF_W  = 2;
  localparam int LPP_W = 2;
  localparam int VP_W  = 2;
  localparam int VSW_W = 1;
  localparam int HCW   = $clog2(PU * (2 ** PPL_W) + 3 * (2 ** HF_W) + 1);
  localparam int VCW   = $clog2((2 ** LPP_W) + 2 * (2 ** VP_W) + (2 ** VSW_W) + 1);
  localparam int WD_CYCLES = 190000;

  logic clk_i = 1'b0, rst_ni = 1'b0, enable_i = 1'b0;
  logic [PPL_W-1:0] ppl_i = '0;
  logic [HF_W-1:0]  hfp_i = '0, hsw_i = '0, hbp_i = '0;
  logic [LPP_W-1:0] lpp_i = '0;
  logic [VP_W-1:0]  vfp_i = '0, vbp_i = '0;
  logic [VSW_W-1:0] vsw_i = '0;
  logic hs_inv_i = 1'b0, vs_inv_i = 1'b0;
  logic hsync_o, vsync_o, de_o, eof_o, frame_done_o;
  logic [HCW-1:0] pix_cnt_o;
  logic [VCW-1:0] line_cnt_o;

  int checks = 0, errors = 0;
  int e_hae, e_hss, e_hse, e_htot, e_vae, e_vss, e_vse, e_vtot, e_hinv, e_vinv;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  raster_timing_gen #(
    .PIX_UNIT(PU), .PPL_W(PPL_W), .HF_W(HF_W), .LPP_W(LPP_W), .VP_W(VP_W), .VSW_W(VSW_W)
  ) u_raster_timing_gen (
    .clk_i, .rst_ni, .enable_i, .ppl_i, .hfp_i, .hsw_i, .hbp_i, .lpp_i, .vfp_i,
    .vsw_i, .vbp_i, .hs_inv_i, .vs_inv_i, .hsync_o, .vsync_o, .de_o,
    .pix_cnt_o, .line_cnt_o, .eof_o, .frame_done_o
  );

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic apply_cfg(input int ppl, hfp, hsw, hbp, lpp, vfp, vsw, vbp, hinv, vinv);
    ppl_i = PPL_W'(ppl); hfp_i = HF_W'(hfp); hsw_i = HF_W'(hsw); hbp_i = HF_W'(hbp);
    lpp_i = LPP_W'(lpp); vfp_i = VP_W'(vfp); vsw_i = VSW_W'(vsw); vbp_i = VP_W'(vbp);
    hs_inv_i = hinv[0]; vs_inv_i = vinv[0];
    e_hae  = (ppl + 1) * PU;
    e_hss  = e_hae + hfp + 1;
    e_hse  = e_hss + hsw + 1;
    e_htot = e_hse + hbp + 1;
    e_vae  = lpp + 1;
    e_vss  = e_vae + vfp;
    e_vse  = e_vss + vsw + 1;
    e_vtot = e_vse + vbp;
    e_hinv = hinv;
    e_vinv = vinv;
  endtask

  task automatic run_cfg(input int nframes, input bit perturb);
    bit seen;
    int vsf;
    // R4 R5: idle level follows polarity
    chk_eq("R4", "idle hsync", int'(hsync_o), e_hinv);
    chk_eq("R5", "idle vsync", int'(vsync_o), e_vinv);
    enable_i = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 6 && !seen; i++) begin
      tick();
      if (de_o) seen = 1'b1;
    end
    chk_eq("R8", "start seen", int'(seen), 1);
    if (!seen) begin
      enable_i = 1'b0;
      repeat (e_htot * e_vtot + 8) tick();
      return;
    end
    vsf = 0;
    for (int f = 0; f < nframes; f++) begin
      for (int v = 0; v < e_vtot; v++) begin
        for (int h = 0; h < e_htot; h++) begin
          if (h == e_hse) vsf = (v >= e_vss && v < e_vse) ? 1 : 0;
          chk_eq("R1", "pix", int'(pix_cnt_o), h);
          chk_eq("R2", "line", int'(line_cnt_o), v);
          chk_eq("R3", "de", int'(de_o), (h < e_hae && v < e_vae) ? 1 : 0);
          chk_eq("R4", "hsync", int'(hsync_o), ((h >= e_hss && h < e_hse) ? 1 : 0) ^ e_hinv);
          chk_eq("R5", "vsync", int'(vsync_o), vsf ^ e_vinv);
          chk_eq("R6", "eof", int'(eof_o), (h == e_htot - 1 && v == e_vtot - 1) ? 1 : 0);
          chk_eq("R7", "no early done", int'(frame_done_o), 0);
          if (f > 0 && v == 0 && h == 0)
            chk_eq("R8", "back to back start", int'(de_o), 1);
          if (perturb && (f > 0 || v > 0))
            chk_eq("R9", "pix with fields changed", int'(pix_cnt_o), h);
          if (f == nframes - 1 && v == 0 && h == 1) enable_i = 1'b0;
          if (perturb && f == 0 && v == 0 && h == 2) begin
            hfp_i = ~hfp_i; hbp_i = ~hbp_i; hsw_i = ~hsw_i; ppl_i = ~ppl_i;
            lpp_i = ~lpp_i; vfp_i = ~vfp_i; vbp_i = ~vbp_i;
            hs_inv_i = ~hs_inv_i; vs_inv_i = ~vs_inv_i;
          end
          tick();
        end
      end
    end
    chk_eq("R7", "frame done", int'(frame_done_o), 1);
    chk_eq("R7", "de after stop", int'(de_o), 0);
    chk_eq("R7", "pix after stop", int'(pix_cnt_o), 0);
    chk_eq("R7", "line after stop", int'(line_cnt_o), 0);
    chk_eq("R4", "hsync after stop", int'(hsync_o), e_hinv);
    chk_eq("R5", "vsync after stop", int'(vsync_o), e_vinv);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk_eq("R7", "done single", int'(frame_done_o), 0);
      chk_eq("R7", "idle de", int'(de_o), 0);
      chk_eq("R7", "idle eof", int'(eof_o), 0);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
    summary();
    $finish;
  end

  initial begin
    int idx;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R10
    chk_eq("R10", "hsync", int'(hsync_o), 0);
    chk_eq("R10", "vsync", int'(vsync_o), 0);
    chk_eq("R10", "de", int'(de_o), 0);
    chk_eq("R10", "eof", int'(eof_o), 0);
    chk_eq("R10", "done", int'(frame_done_o), 0);
    chk_eq("R10", "pix", int'(pix_cnt_o), 0);
    chk_eq("R10", "line", int'(line_cnt_o), 0);
    idx = 0;
    for (int pp = 0; pp < 2; pp++)
      for (int hs = 0; hs < 4; hs++)
        for (int lp = 0; lp < 2; lp++)
          for (int vf = 0; vf < 2; vf++)
            for (int vw = 0; vw < 2; vw++)
              for (int vb = 0; vb < 2; vb++) begin
                apply_cfg(pp * 3, hs, 3 - hs, (hs + 1) % 4, lp * 3, vf * 3, vw, vb * 3,
                          idx % 2, (idx / 2) % 2);
                repeat (2) tick();
                run_cfg((idx % 8 == 3) ? 2 : 1, (idx % 8 == 6) || (idx % 16 == 3));
                idx++;
              end
    summary();
    $finish;
  end

endmodule